// File: doc/BRIEF.md
# BCD Calendar Alarm Matcher

This block watches a running calendar, presented to it as BCD fields, and compares it with six alarm values: seconds, minutes, hours, day of month, month and a three-digit year. Each alarm value has its own enable bit. The per-field results are ORed, so one enabled field that matches is enough to raise the alarm. The comparison is made only in the clock cycle in which the one-pulse-per-second strobe is high. The calendar source must already show the advanced time in that cycle.

A match sets a sticky status bit, and a level interrupt line follows that bit. Software clears the bit by writing a one to bit 1 of the interrupt status write port. The block does not count the calendar and does not decode a bus. It takes write strobes for three registers and reads the calendar fields from its inputs.

Top module: `bcd_alarm_matcher`

## Requirements
- R1: After reset the status bit and the interrupt are low, and every alarm value and the control register hold zero. A calendar that reads all zeros therefore matches once all enables are set.
- R2: The field selector picks the alarm value to write: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year; selectors 6 and 7 write nothing. Control bit n enables field n for n = 0 to 5. A field whose bit is clear never causes a match.
- R3: Control bit 6 is the global alarm enable. While it is clear, no strobe can set the status bit.
- R4: Field results are ORed. With several fields enabled, a match on any one of them sets the status bit, and if none matches the bit stays clear.
- R5: A comparison happens only in a cycle where `sec_tick` is high. The status bit is set at the clock edge that ends that cycle. Without a strobe, a matching calendar has no effect.
- R6: Alarm values are masked when written: seconds and minutes keep bits 6:0, hours and day keep bits 5:0, month keeps bits 4:0, and year keeps bits 11:0. The compare uses the masked value against the full calendar field, so bits that were cut off cannot match.
- R7: The year is compared as three BCD digits over all 12 bits. Bits 7:0 hold the tens and units digits and bits 11:8 hold the hundreds digit, so a difference in the hundreds digit alone prevents a match.
- R8: `alm_irq` is a level that is high exactly while the status bit is set.
- R9: A status write with bit 1 set clears the status bit on the next edge. A status write with bit 1 clear has no effect, and bit 0 of the status write is ignored.
- R10: The status bit is sticky. Further matches keep it set. If a match and a clearing write fall in the same cycle, the match wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe after the calendar advances one second |
| cal_sec | input | CAL_W | Current seconds, BCD |
| cal_min | input | CAL_W | Current minutes, BCD |
| cal_hour | input | CAL_W | Current hours, BCD |
| cal_day | input | CAL_W | Current day of month, BCD |
| cal_mon | input | CAL_W | Current month, BCD |
| cal_year | input | YR_W | Current year, three BCD digits |
| ctl_we | input | 1 | Write strobe for the alarm control register |
| ctl_wdata | input | 8 | Control data: bits 5:0 field enables, bit 6 global enable |
| fld_we | input | 1 | Write strobe for an alarm value |
| fld_sel | input | 3 | Alarm value selector |
| fld_wdata | input | YR_W | Alarm value data, before masking |
| sts_we | input | 1 | Write strobe for the interrupt status register |
| sts_wdata | input | 2 | Status write data; a one in bit 1 clears the alarm |
| alm_sts | output | 1 | Sticky alarm status bit |
| alm_irq | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with its default widths: 8-bit calendar fields and a 12-bit year. At these widths every seconds, minutes, hours, day and month alarm value can be written and checked. For each written value the bench verifies a hit on the masked value, a miss on the unmasked value and a miss on a neighbouring value. The year is swept over a dense stride of its 4096 codes, so each hundreds digit is reached. Directed cases cover the global enable, the OR of several fields, strobe gating, clearing and the same-cycle collision of a set and a clear.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int NFLD  = 6;
    localparam int FLD_W = 12;
    localparam int CTL_W = 7;
    localparam int GLB_BIT = 6;
    localparam int STS_ALM_BIT = 1;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DAY  = 3'd3,
        FLD_MON  = 3'd4,
        FLD_YEAR = 3'd5
    } fld_e;

    typedef logic [NFLD-1:0][FLD_W-1:0] fld_arr_t;

    // Storage mask applied to each alarm value as it is written.
    function automatic logic [FLD_W-1:0] fld_mask(input int idx);
        logic [FLD_W-1:0] m;
        case (idx)
            0, 1:    m = 12'h07F;
            2, 3:    m = 12'h03F;
            4:       m = 12'h01F;
            default: m = 12'hFFF;
        endcase
        return m;
    endfunction

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        fld_arr_t         val;
    } regs_t;

    typedef struct packed {
        logic sts;
    } sts_t;

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             fld_we,
    input  logic [2:0]       fld_sel,
    input  logic [FLD_W-1:0] fld_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output fld_arr_t         val_q
);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_we) begin
            r_d.ctl = ctl_wdata[CTL_W-1:0];
        end
        for (int i = 0; i < NFLD; i++) begin
            if (fld_we && (int'(fld_sel) == i)) begin
                r_d.val[i] = fld_wdata & fld_mask(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_q = r_q.ctl;
    assign val_q = r_q.val;

endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_pkg::*;
(
    input  fld_arr_t          cur,
    input  fld_arr_t          alm,
    input  logic [NFLD-1:0]   en,
    output logic [NFLD-1:0]   hit
);

    genvar g;
    generate
        for (g = 0; g < NFLD; g++) begin : g_fld
            always_comb begin
                hit[g] = en[g] && (cur[g] == alm[g]);
            end
        end
    endgenerate

endmodule

// File: rtl/alm_sts.sv
module alm_sts
    import alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       sts_we,
    input  logic [1:0] sts_wdata,
    output logic       sts
);

    sts_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sts_we && sts_wdata[STS_ALM_BIT]) begin
            s_d.sts = 1'b0;
        end
        if (fire) begin
            s_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sts = s_q.sts;

endmodule

// File: rtl/bcd_alarm_matcher.sv
module bcd_alarm_matcher
    import alm_pkg::*;
#(
    parameter int CAL_W = 8,
    parameter int YR_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [CAL_W-1:0] cal_sec,
    input  logic [CAL_W-1:0] cal_min,
    input  logic [CAL_W-1:0] cal_hour,
    input  logic [CAL_W-1:0] cal_day,
    input  logic [CAL_W-1:0] cal_mon,
    input  logic [YR_W-1:0]  cal_year,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             fld_we,
    input  logic [2:0]       fld_sel,
    input  logic [YR_W-1:0]  fld_wdata,
    input  logic             sts_we,
    input  logic [1:0]       sts_wdata,
    output logic             alm_sts,
    output logic             alm_irq
);

    localparam int PAD_C = FLD_W - CAL_W;
    localparam int PAD_Y = FLD_W - YR_W;

    logic [CTL_W-1:0] ctl_q;
    fld_arr_t         val_q;
    fld_arr_t         cur;
    logic [NFLD-1:0]  hit;
    logic             glob_en;
    logic             fire;

    always_comb begin
        cur[FLD_SEC]  = {{PAD_C{1'b0}}, cal_sec};
        cur[FLD_MIN]  = {{PAD_C{1'b0}}, cal_min};
        cur[FLD_HOUR] = {{PAD_C{1'b0}}, cal_hour};
        cur[FLD_DAY]  = {{PAD_C{1'b0}}, cal_day};
        cur[FLD_MON]  = {{PAD_C{1'b0}}, cal_mon};
        cur[FLD_YEAR] = {{PAD_Y{1'b0}}, cal_year};
    end

    alm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .fld_we    (fld_we),
        .fld_sel   (fld_sel),
        .fld_wdata ({{PAD_Y{1'b0}}, fld_wdata}),
        .ctl_q     (ctl_q),
        .val_q     (val_q)
    );

    alm_cmp u_cmp (
        .cur (cur),
        .alm (val_q),
        .en  (ctl_q[NFLD-1:0]),
        .hit (hit)
    );

    assign glob_en = ctl_q[GLB_BIT];
    assign fire    = sec_tick && glob_en && (|hit);

    alm_sts u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .sts       (alm_sts)
    );

    assign alm_irq = alm_sts;

endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       glob_en,
    input logic [5:0] hit,
    input logic       sts_we,
    input logic [1:0] sts_wdata,
    input logic       alm_sts
);

    // R3
    rise_needs_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_sts) |-> $past(glob_en));

    // R5
    rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_sts) |-> $past(sec_tick));

    // R4
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_sts) |-> $past(|hit));

    // R9
    fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alm_sts) |-> $past(sts_we && sts_wdata[1]));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_sts && !(sts_we && sts_wdata[1])) |=> alm_sts);

    // R10
    match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && glob_en && (|hit)) |=> alm_sts);

endmodule

bind bcd_alarm_matcher bcd_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .glob_en   (glob_en),
    .hit       (hit),
    .sts_we    (sts_we),
    .sts_wdata (sts_wdata),
    .alm_sts   (alm_sts)
);

// File: tb/sim_bcd_alarm_matcher.sv
`timescale 1ns/1ps
module sim_bcd_alarm_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  cal_sec = '0, cal_min = '0, cal_hour = '0, cal_day = '0, cal_mon = '0;
    logic [11:0] cal_year = '0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        fld_we = 1'b0;
    logic [2:0]  fld_sel = '0;
    logic [11:0] fld_wdata = '0;
    logic        sts_we = 1'b0;
    logic [1:0]  sts_wdata = '0;
    logic        alm_sts, alm_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bcd_alarm_matcher u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_day(cal_day), .cal_mon(cal_mon), .cal_year(cal_year),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fld_we(fld_we), .fld_sel(fld_sel), .fld_wdata(fld_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .alm_sts(alm_sts), .alm_irq(alm_irq)
    );

    function automatic int mask_of(input int f);
        if (f <= 1) return 'h7F;
        if (f <= 3) return 'h3F;
        if (f == 4) return 'h1F;
        return 'hFFF;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int exp);
        chk(req, int'(alm_sts), exp);
        chk({req, " R8"}, int'(alm_irq), exp);
    endtask

    task automatic wr_ctl(input int v);
        ctl_wdata = v[7:0]; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_fld(input int sel, input int v);
        fld_sel = sel[2:0]; fld_wdata = v[11:0]; fld_we = 1'b1;
        @(negedge clk); fld_we = 1'b0;
    endtask

    task automatic wr_sts(input int v);
        sts_wdata = v[1:0]; sts_we = 1'b1;
        @(negedge clk); sts_we = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic set_cal(input int f, input int v);
        case (f)
            0: cal_sec  = v[7:0];
            1: cal_min  = v[7:0];
            2: cal_hour = v[7:0];
            3: cal_day  = v[7:0];
            4: cal_mon  = v[7:0];
            default: cal_year = v[11:0];
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_out("R1 reset", 0);
        // R1 registers zero: all-zero calendar matches every field
        wr_ctl('h7F);
        tick();
        chk_out("R1 zero regs", 1);
        wr_sts(2);
        chk_out("R9 clear", 0);

        // R5 no strobe, no effect
        wr_ctl('h41);
        repeat (5) @(negedge clk);
        chk_out("R5 no tick", 0);
        tick();
        chk_out("R5 tick edge", 1);
        wr_sts(2);

        // R3 global enable clear
        wr_ctl('h01);
        tick();
        chk_out("R3 global off", 0);

        // R4 OR of fields, R2 enable bits
        wr_fld(0, 'h10); wr_fld(1, 'h20);
        wr_ctl('h43);
        cal_sec = 'h10; cal_min = 'h55; tick();
        chk_out("R4 sec only", 1); wr_sts(2);
        cal_sec = 'h11; cal_min = 'h20; tick();
        chk_out("R4 min only", 1); wr_sts(2);
        cal_sec = 'h11; cal_min = 'h21; tick();
        chk_out("R4 none", 0);
        wr_ctl('h42);
        cal_sec = 'h10; tick();
        chk_out("R2 disabled field", 0);
        // R2 selectors 6 and 7 write nothing
        wr_fld(6, 'h21); wr_fld(7, 'h21);
        wr_ctl('h42); cal_min = 'h20; tick();
        chk_out("R2 bad selector", 1); wr_sts(2);

        // R7 hundreds digit alone differs
        wr_fld(5, 'h219); wr_ctl('h60);
        cal_year = 'h319; tick();
        chk_out("R7 hundreds differ", 0);
        cal_year = 'h219; tick();
        chk_out("R7 year match", 1);

        // R9 writes without bit1
        wr_sts(1);
        chk_out("R9 bit0 ignored", 1);
        wr_sts(0);
        chk_out("R9 zero write", 1);
        // R10 sticky across another match
        tick();
        chk_out("R10 rematch", 1);
        // R10 match and clear in same cycle
        sts_wdata = 2'b10; sts_we = 1'b1; sec_tick = 1'b1;
        @(negedge clk); sts_we = 1'b0; sec_tick = 1'b0;
        chk_out("R10 collision", 1);
        wr_sts(2);
        chk_out("R9 final clear", 0);

        // R6 R2 sweep over every field
        for (int f = 0; f < 6; f++) begin
            int lim;
            int stp;
            lim = (f == 5) ? 4096 : 256;
            stp = (f == 5) ? 3 : 1;
            wr_ctl('h40 | (1 << f));
            for (int w = 0; w < lim; w += stp) begin
                int m;
                m = w & mask_of(f);
                wr_fld(f, w);
                set_cal(f, m); tick();
                chk_out("R6 masked hit", 1);
                wr_sts(2);
                if (m != w) begin
                    set_cal(f, w); tick();
                    chk_out("R6 unmasked miss", 0);
                end
                set_cal(f, m ^ 1); tick();
                chk_out("R2 neighbour miss", 0);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule